// File: doc/BRIEF.md
# Three-Phase PWM Compare Timer

This block is the counting core of a three-phase PWM generator. A counter steps on an enable pulse taken from the module clock. The enable passes through a prescaler that divides by a power of two, and an optional further divide-by-256 stage can follow it. The counter runs in one of two alignments. In edge alignment it counts up and wraps to zero. In center alignment it counts up past the turning point by one and then counts back down to zero. A pulse marks each turn at the top, and in center alignment a second pulse marks each turn at the bottom.

The turning point comes from an active period register. That register is double-buffered. Software places the next value on a shadow input and then arms a transfer. The copy into the active register happens on the next top turn, or on the next bottom turn in center alignment. The armed flag clears itself after the copy. Three channels compare the count against their own compare values, and each channel drives a state bit. In edge alignment these bits form leading-edge PWM waveforms. In center alignment they form symmetric PWM waveforms.

Top module: `pwm3_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `count`, `dir_down`, `ch_state`, `period_match`, `one_match`, `period_active` and `xfer_pending`. An `xfer_arm` pulse during reset has no effect.
- R2: While `run` is high, the counter takes a step once every 2^`clk_sel` × (`ext_div_en` ? 256 : 1) clock cycles. The first step comes that many cycles after `run` rises, because the dividers restart whenever `run` is low.
- R3: While `run` is low, `count`, `dir_down` and `ch_state` hold their values, and no pulse is produced.
- R4: With `center` = 0 (edge alignment), a step adds one to `count`. A step taken while `count` equals `period_active` loads 0 instead. After any step `dir_down` is 0.
- R5: With `center` = 1 (center alignment), a step taken while counting up adds one. If that step was taken at `period_active`, it also sets `dir_down` to 1, so the count reaches `period_active`+1. While counting down a step subtracts one. A step taken at count 1 or 0 loads 0 and clears `dir_down`.
- R6: `period_match` is high for exactly the one clock after a step taken while counting up with `count` equal to `period_active`. This holds in both alignments.
- R7: `one_match` is high for exactly the one clock after a center-alignment down step that lands on 0. It is never high after an edge-alignment step.
- R8: `period_active` takes the value of `shadow_period` only at a step that produces `period_match` or `one_match` while `xfer_pending` is 1. At every other time it holds, whatever `shadow_period` does.
- R9: An `xfer_arm` pulse sets `xfer_pending` at the next edge. A transfer clears it. If an arm and a transfer fall on the same edge, the flag stays set.
- R10: In edge alignment, channel k's state bit (bit k of `ch_state`) is set by a step taken at count equal to compare value k. It is cleared by the wrap step. When both apply, clearing wins.
- R11: In center alignment, channel k's state bit is set by an up step taken at count equal to compare value k, and cleared by a down step taken at that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Counting enable |
| center | input | 1 | 0 = edge alignment, 1 = center alignment |
| clk_sel | input | SEL_W (2) | Prescaler exponent: divide by 2^clk_sel |
| ext_div_en | input | 1 | Adds the divide-by-256 stage |
| shadow_period | input | CNT_W (16) | Next period value, written by software |
| xfer_arm | input | 1 | Pulse that arms a shadow transfer |
| cmp_vals | input | NUM_CH*CNT_W (48) | Compare value of channel k in bits [16k+15:16k] |
| count | output | CNT_W (16) | Current count |
| dir_down | output | 1 | 1 while counting down |
| period_match | output | 1 | Top-turn pulse |
| one_match | output | 1 | Bottom-turn pulse (center alignment) |
| period_active | output | CNT_W (16) | Active period value |
| xfer_pending | output | 1 | Shadow transfer armed |
| ch_state | output | NUM_CH (3) | Channel state bits |

## Verification
The hardest case to reach from the ports is an `xfer_arm` pulse on the same edge as a transfer, because the flag then has to survive its own clearing. The bench reaches it by pulsing `xfer_arm` on every clock for a window that spans both top and bottom turns of a short center-aligned period, with `shadow_period` changing on each pulse. The divide-by-256 steps are just as awkward to reach. The sweep waits out four full divided intervals for every prescaler setting, with and without that stage, and checks the count on every cycle in between.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_dir_e;

   typedef enum logic {
      ALIGN_EDGE   = 1'b0,
      ALIGN_CENTER = 1'b1
   } align_e;

   // Turn events produced by one counter step
   typedef struct packed {
      logic top;
      logic bot;
   } turn_t;

endpackage

// File: rtl/pwm3_prescale.sv
module pwm3_prescale #(
   parameter int SEL_W = 2,
   parameter int EXT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   input  logic             ext_en,
   output logic             step
);

   localparam int PRE_W = (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pre_cnt;
   logic [PRE_W-1:0] pre_mask;
   logic             base;

   always_comb begin
      pre_mask = PRE_W'((32'd1 << sel) - 32'd1);
      base     = run && ((pre_cnt & pre_mask) == pre_mask);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) pre_cnt <= '0;
      else                pre_cnt <= pre_cnt + 1'b1;
   end

   generate
      if (EXT_W > 0) begin : g_ext
         logic [EXT_W-1:0] ext_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) ext_cnt <= '0;
            else if (base)      ext_cnt <= ext_cnt + 1'b1;
         end
         assign step = base && (!ext_en || (&ext_cnt));
      end else begin : g_noext
         assign step = base;
      end
   endgenerate

endmodule

// File: rtl/pwm3_count.sv
module pwm3_count
   import pwm3_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  align_e           align,
   input  logic [CNT_W-1:0] shadow,
   input  logic             arm,
   output logic [CNT_W-1:0] cnt,
   output cnt_dir_e         dir,
   output logic             at_per,
   output turn_t            turn_q,
   output logic             xfer_en,
   output logic [CNT_W-1:0] period
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   turn_t            turn;
   logic [CNT_W-1:0] cnt_nx;
   cnt_dir_e         dir_nx;
   logic             xfer;

   always_comb begin
      at_per   = (cnt == period);
      turn.top = step && at_per && ((align == ALIGN_EDGE) || (dir == CNT_UP));
      turn.bot = step && (align == ALIGN_CENTER) && (dir == CNT_DOWN) && (cnt <= ONE);
      cnt_nx   = cnt;
      dir_nx   = dir;
      if (align == ALIGN_EDGE) begin
         dir_nx = CNT_UP;
         cnt_nx = at_per ? '0 : cnt + ONE;
      end else if (dir == CNT_UP) begin
         cnt_nx = cnt + ONE;
         if (at_per) dir_nx = CNT_DOWN;
      end else if (cnt <= ONE) begin
         cnt_nx = '0;
         dir_nx = CNT_UP;
      end else begin
         cnt_nx = cnt - ONE;
      end
      xfer = (turn.top || turn.bot) && xfer_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         dir     <= CNT_UP;
         turn_q  <= '0;
         xfer_en <= 1'b0;
         period  <= '0;
      end else begin
         if (step) begin
            cnt <= cnt_nx;
            dir <= dir_nx;
         end
         turn_q  <= turn;
         if (xfer) period <= shadow;
         xfer_en <= arm || (xfer_en && !xfer);
      end
   end

endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan
   import pwm3_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  align_e           align,
   input  cnt_dir_e         dir,
   input  logic [CNT_W-1:0] cnt,
   input  logic             at_per,
   input  logic [CNT_W-1:0] cmp,
   output logic             st
);

   logic hit;
   assign hit = (cnt == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= 1'b0;
      end else if (step) begin
         if (align == ALIGN_EDGE) begin
            if (at_per)   st <= 1'b0;
            else if (hit) st <= 1'b1;
         end else if (hit) begin
            st <= (dir == CNT_UP);
         end
      end
   end

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
   import pwm3_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3,
   parameter int SEL_W  = 2,
   parameter int EXT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    center,
   input  logic [SEL_W-1:0]        clk_sel,
   input  logic                    ext_div_en,
   input  logic [CNT_W-1:0]        shadow_period,
   input  logic                    xfer_arm,
   input  logic [NUM_CH*CNT_W-1:0] cmp_vals,
   output logic [CNT_W-1:0]        count,
   output logic                    dir_down,
   output logic                    period_match,
   output logic                    one_match,
   output logic [CNT_W-1:0]        period_active,
   output logic                    xfer_pending,
   output logic [NUM_CH-1:0]       ch_state
);

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_w
         $error("pwm3_timer: CNT_W must lie in 4..32");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pwm3_timer: NUM_CH must be at least 1");
      end
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("pwm3_timer: SEL_W must lie in 1..4");
      end
      if (EXT_W < 0 || EXT_W > 16) begin : g_bad_ext
         $error("pwm3_timer: EXT_W must lie in 0..16");
      end
   endgenerate

   logic     step;
   logic     at_per;
   cnt_dir_e dir;
   turn_t    turn_q;
   align_e   align;

   assign align = align_e'(center);

   pwm3_prescale #(.SEL_W(SEL_W), .EXT_W(EXT_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .sel    (clk_sel),
      .ext_en (ext_div_en),
      .step   (step)
   );

   pwm3_count #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .align   (align),
      .shadow  (shadow_period),
      .arm     (xfer_arm),
      .cnt     (count),
      .dir     (dir),
      .at_per  (at_per),
      .turn_q  (turn_q),
      .xfer_en (xfer_pending),
      .period  (period_active)
   );

   genvar k;
   generate
      for (k = 0; k < NUM_CH; k++) begin : g_ch
         pwm3_chan #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step),
            .align  (align),
            .dir    (dir),
            .cnt    (count),
            .at_per (at_per),
            .cmp    (cmp_vals[k*CNT_W +: CNT_W]),
            .st     (ch_state[k])
         );
      end
   endgenerate

   assign dir_down     = (dir == CNT_DOWN);
   assign period_match = turn_q.top;
   assign one_match    = turn_q.bot;

endmodule

// File: rtl/pwm3_timer_chk.sv
module pwm3_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic              center,
   input logic [CNT_W-1:0]  count,
   input logic              dir_down,
   input logic              period_match,
   input logic              one_match,
   input logic [CNT_W-1:0]  period_active,
   input logic              xfer_pending,
   input logic              xfer_arm,
   input logic [CNT_W-1:0]  shadow_period,
   input logic [NUM_CH-1:0] ch_state
);

   logic primed = 1'b0;
   always_ff @(posedge clk) primed <= 1'b1;

   AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      step && !center && (count == period_active) |=> (count == '0)); // R4

   AST_EDGE_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
      step && !center |=> !dir_down); // R4

   AST_CENTER_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      primed && step && center && !dir_down && (count == period_active)
      |=> dir_down && (count == $past(count) + 1'b1)); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      primed && !step |=> $stable(count) && $stable(dir_down) && $stable(ch_state)); // R3

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      period_match |-> !one_match); // R7

   AST_ONE_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
      primed && one_match |-> $past(center)); // R7

   AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      primed && period_match && $past(xfer_pending) && !$past(xfer_arm) && $past(rst_n)
      |-> !xfer_pending && (period_active == $past(shadow_period))); // R8

   AST_NO_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(rst_n) && !$past(xfer_pending) |-> $stable(period_active)); // R8

   AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_arm |=> xfer_pending); // R9

endmodule

bind pwm3_timer pwm3_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .step          (step),
   .center        (center),
   .count         (count),
   .dir_down      (dir_down),
   .period_match  (period_match),
   .one_match     (one_match),
   .period_active (period_active),
   .xfer_pending  (xfer_pending),
   .xfer_arm      (xfer_arm),
   .shadow_period (shadow_period),
   .ch_state      (ch_state)
);

// File: tb/sim_pwm3_timer.sv
`timescale 1ns/1ps
module sim_pwm3_timer;

   localparam int W  = 16;
   localparam int NC = 3;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic          center = 1'b0;
   logic [SW-1:0] clk_sel = '0;
   logic          ext_div_en = 1'b0;
   logic [W-1:0]  shadow_period = '0;
   logic          xfer_arm = 1'b0;
   logic [NC*W-1:0] cmp_vals = '0;
   logic [W-1:0]  count;
   logic          dir_down;
   logic          period_match;
   logic          one_match;
   logic [W-1:0]  period_active;
   logic          xfer_pending;
   logic [NC-1:0] ch_state;

   always #2.5 clk = ~clk;

   pwm3_timer u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .center(center), .clk_sel(clk_sel),
      .ext_div_en(ext_div_en), .shadow_period(shadow_period), .xfer_arm(xfer_arm),
      .cmp_vals(cmp_vals), .count(count), .dir_down(dir_down),
      .period_match(period_match), .one_match(one_match),
      .period_active(period_active), .xfer_pending(xfer_pending), .ch_state(ch_state)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [W-1:0]  m_cnt = '0;
   logic          m_dir = 1'b0;
   logic          m_pm = 1'b0;
   logic          m_om = 1'b0;
   logic [W-1:0]  m_per = '0;
   logic          m_xen = 1'b0;
   logic [NC-1:0] m_st = '0;
   int            runcyc = 0;
   string         cnt_tag = "";

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] cmp_of(input int k);
      return cmp_vals[k*W +: W];
   endfunction

   task automatic model_edge();
      int  n;
      bit  tk, atp, top, bot;
      logic [W-1:0] c0;
      logic d0;
      if (!rst_n) begin
         m_cnt = '0; m_dir = 0; m_pm = 0; m_om = 0; m_per = '0; m_xen = 0; m_st = '0;
         runcyc = 0;
         return;
      end
      n  = (1 << clk_sel) * (ext_div_en ? 256 : 1);
      tk = 0;
      if (run) begin
         tk = ((runcyc + 1) % n) == 0;
         runcyc++;
      end else begin
         runcyc = 0;
      end
      c0  = m_cnt; d0 = m_dir;
      atp = (c0 == m_per);
      top = tk && atp && (!center || !d0);
      bot = tk && center && d0 && (c0 <= 1);
      if (tk) begin
         for (int k = 0; k < NC; k++) begin
            if (!center) begin
               if (atp) m_st[k] = 1'b0;
               else if (c0 == cmp_of(k)) m_st[k] = 1'b1;
            end else if (c0 == cmp_of(k)) begin
               m_st[k] = !d0;
            end
         end
         if (!center) begin
            m_dir = 0;
            m_cnt = atp ? '0 : c0 + 1'b1;
         end else if (!d0) begin
            m_cnt = c0 + 1'b1;
            if (atp) m_dir = 1;
         end else if (c0 <= 1) begin
            m_cnt = '0; m_dir = 0;
         end else begin
            m_cnt = c0 - 1'b1;
         end
      end
      m_pm = top;
      m_om = bot;
      if ((top || bot) && m_xen) m_per = shadow_period;
      m_xen = xfer_arm || (m_xen && !((top || bot)));
   endtask

   task automatic compare_all();
      string tc, ts;
      tc = (cnt_tag != "") ? cnt_tag : (center ? "R5" : "R4");
      ts = center ? "R11" : "R10";
      chk(count == m_cnt, tc, "count", count, m_cnt);
      chk(dir_down == m_dir, tc, "dir_down", dir_down, m_dir);
      chk(period_match == m_pm, "R6", "period_match", period_match, m_pm);
      chk(one_match == m_om, "R7", "one_match", one_match, m_om);
      chk(period_active == m_per, "R8", "period_active", period_active, m_per);
      chk(xfer_pending == m_xen, "R9", "xfer_pending", xfer_pending, m_xen);
      chk(ch_state == m_st, ts, "ch_state", ch_state, m_st);
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         #1;
         compare_all();
      end
   endtask

   task automatic set_cmps(input int a, input int b, input int c);
      cmp_vals = {W'(c), W'(b), W'(a)};
   endtask

   // sync reset, then arm a transfer of p so the first turn loads it
   task automatic restart(input bit cen, input int p);
      run = 0; rst_n = 0; cnt_tag = "R1";
      cyc(1);
      rst_n = 1; center = cen; shadow_period = W'(p); xfer_arm = 1;
      cyc(1);
      xfer_arm = 0; cnt_tag = "";
   endtask

   initial begin
      // R1: reset with busy inputs
      rst_n = 0; run = 1; xfer_arm = 1; shadow_period = 16'd7; center = 1;
      cnt_tag = "R1";
      cyc(3);
      chk(count == 0 && !dir_down && ch_state == 0 && !xfer_pending && period_active == 0,
          "R1", "reset state", {count, period_active}, 0);
      xfer_arm = 0; run = 0; cnt_tag = "";

      // R4 R5 R6 R7 R10 R11: sweep of periods, alignments and compare layouts
      for (int cen = 0; cen < 2; cen++) begin
         for (int p = 0; p < 6; p++) begin
            for (int lay = 0; lay < 2; lay++) begin
               restart(cen[0], p);
               if (lay == 0) set_cmps(p, p / 2, p + 1);
               else          set_cmps(0, 1, (p + 1) / 2);
               run = 1;
               cyc(3 * (2 * p + 2) + 4);
               chk(period_active == W'(p), cen ? "R5" : "R4", "period loaded", period_active, p);
            end
         end
      end

      // R8: shadow changes without arming leave the period alone
      restart(1'b1, 4);
      set_cmps(1, 3, 5);
      run = 1;
      cyc(12);
      shadow_period = 16'd9;
      cyc(25);
      chk(period_active == 16'd4, "R8", "unarmed shadow ignored", period_active, 4);
      xfer_arm = 1; cyc(1); xfer_arm = 0;
      cyc(40);
      chk(period_active == 16'd9, "R8", "armed transfer", period_active, 9);

      // R9: arm on every cycle across turns, shadow moving
      restart(1'b1, 2);
      set_cmps(0, 1, 2);
      run = 1;
      for (int i = 0; i < 30; i++) begin
         xfer_arm = 1; shadow_period = W'(1 + (i % 3));
         cyc(1);
      end
      xfer_arm = 0;
      cyc(20);

      // R3: stop in the middle of a count
      restart(1'b0, 10);
      set_cmps(2, 5, 8);
      run = 1; cyc(17);
      run = 0; cnt_tag = "R3"; cyc(12);
      chk(!period_match && !one_match, "R3", "no pulses while stopped", period_match, 0);
      cnt_tag = ""; run = 1; cyc(15);

      // R2: prescaler sweep, with and without the 256 stage
      restart(1'b0, 3);
      set_cmps(1, 2, 3);
      for (int e = 0; e < 2; e++) begin
         for (int s = 0; s < 4; s++) begin
            run = 0; cyc(1);
            clk_sel = SW'(s); ext_div_en = e[0];
            run = 1; cnt_tag = "R2";
            cyc(4 * (1 << s) * (e ? 256 : 1) + 2);
         end
      end
      cnt_tag = ""; run = 0; clk_sel = '0; ext_div_en = 0; cyc(1);

      // R4 R5: alignment switch while counting down, then reset mid-run (R1)
      restart(1'b1, 5);
      set_cmps(2, 4, 6);
      run = 1; cyc(9);
      center = 0; cyc(20);
      center = 1; cyc(20);
      rst_n = 0; cnt_tag = "R1"; cyc(1);
      rst_n = 1; cnt_tag = ""; cyc(10);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule